// File: doc/BRIEF.md
# Trapping Integer Execute Unit

This block is the integer execute stage of a simple load/store RISC core. It receives one 32-bit instruction word together with the two source register values already read for it, and in the same cycle returns the 32-bit result, the destination register index and a write-enable. The operations covered are signed (trapping) and plain (wrapping) add and subtract, add-immediate in both flavours, bitwise AND, OR and XOR, signed set-on-less-than, load-upper-immediate, constant logical shifts left and right, and constant rotate right.

Signed add, subtract and add-immediate detect two's complement overflow by extending both operands to 33 bits through sign duplication and comparing the top two bits of the sum. On overflow the unit raises a trap flag and withholds the register write; taking the exception is the job of the surrounding pipeline. A write aimed at register 0 is also withheld, and a separate flag tells the register file that a write was dropped for that reason. The all-zero instruction word therefore behaves as a no-operation.

The unit is purely combinational. It has no clock and no state.

Top module: `trap_alu`

## Requirements
- R1: The instruction word is decoded from its primary opcode in bits 31:26. Code 000000 is the register form, with the function code in bits 5:0 and the shift amount in bits 10:6. For the signed add (function 100000) and subtract (function 100010), each operand is extended to 33 bits by copying bit 31. `ovf_trap` is 1 exactly when bit 32 of the 33-bit sum or difference differs from bit 31.
- R2: When `ovf_trap` is 1, `wr_en` is 0. Otherwise a recognised operation writes the low 32 bits of its result, which always appear on `result`.
- R3: The wrapping add (function 100001), the wrapping subtract (function 100011) and the wrapping add-immediate (opcode 001001) compute the same low 32 bits as the signed forms and never set `ovf_trap`.
- R4: Add-immediate (opcode 001000 trapping, 001001 wrapping) sign-extends the immediate in bits 15:0 and adds it to `rs_val`. The destination is the field in bits 20:16.
- R5: Set-on-less-than (function 101010) returns 1 when `rs_val` is less than `rt_val` as signed numbers and 0 otherwise. It never traps.
- R6: Load-upper-immediate (opcode 001111) returns the immediate in bits 31:16 with zeros in bits 15:0. The destination is bits 20:16.
- R7: Shift left (function 000000) and shift right (function 000010, bits 25:21 all zero) move `rt_val` by the shift amount and fill the vacated positions with zeros.
- R8: Function 000010 with bits 25:22 zero and bit 21 set to 1 rotates `rt_val` right by the shift amount, re-inserting at the top the bits that leave at the bottom.
- R9: The all-zero instruction word writes nothing and raises no trap.
- R10: The destination is bits 15:11 for register forms and bits 20:16 for immediate forms. When a recognised operation targets register 0, `wr_en` is 0 and `dst_drop` is 1. In every other case `dst_drop` is 0.
- R11: Functions 100100, 100101 and 100110 give the bitwise AND, OR and XOR of `rs_val` and `rt_val`.
- R12: An unrecognised word gives `wr_en`, `ovf_trap`, `dst_drop`, `dst_idx` and `result` all zero. Unrecognised words include any other opcode or function code, and function 000010 with any of bits 25:22 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to execute |
| rs_val | input | 32 | Value of the first source register (bits 25:21) |
| rt_val | input | 32 | Value of the second source register (bits 20:16) |
| result | output | 32 | Computed value, low 32 bits |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write permitted |
| dst_drop | output | 1 | Write withheld because the destination is register 0 |
| ovf_trap | output | 1 | Signed overflow on a trapping add, subtract or add-immediate |

## Verification
Every output is combinational, so each result is due in the same cycle its instruction is applied, with no register on the path. The driver applies a new instruction 1 ns after a rising edge and queues the expected outputs from an independent model. The monitor pops and compares at the following falling edge, after the inputs have settled and before the next word arrives. Directed words cover the two overflow boundary pairs, destination register 0, the zero word, rotate and shift by 0 and by 31, and malformed shift-right words. A long random run then mixes every operation with random operands.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int REG_W   = 5;

  localparam logic [OPC_W-1:0] OPC_REGFORM = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI_T  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDI_W  = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_UPPER   = 6'b001111;

  localparam logic [FN_W-1:0] FN_SHL    = 6'b000000;
  localparam logic [FN_W-1:0] FN_SHR    = 6'b000010;
  localparam logic [FN_W-1:0] FN_ADD_T  = 6'b100000;
  localparam logic [FN_W-1:0] FN_ADD_W  = 6'b100001;
  localparam logic [FN_W-1:0] FN_SUB_T  = 6'b100010;
  localparam logic [FN_W-1:0] FN_SUB_W  = 6'b100011;
  localparam logic [FN_W-1:0] FN_AND    = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR     = 6'b100101;
  localparam logic [FN_W-1:0] FN_XOR    = 6'b100110;
  localparam logic [FN_W-1:0] FN_LESS   = 6'b101010;

  typedef enum logic [3:0] {
    K_NONE,
    K_ADD_T, K_ADD_W, K_SUB_T, K_SUB_W,
    K_ADDI_T, K_ADDI_W,
    K_AND, K_OR, K_XOR, K_LESS, K_UPPER,
    K_SHL, K_SHR, K_ROR
  } alu_kind_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ROT} shift_kind_e;

endpackage

// File: rtl/trap_alu_decode.sv
module trap_alu_decode
  import trap_alu_pkg::*;
#(
  parameter bit ROT_EN = 1'b1
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [4:0]       rs_field,
  input  logic [FN_W-1:0]  fn,
  output alu_kind_e        kind,
  output logic             use_rd
);

  always_comb begin
    kind   = K_NONE;
    use_rd = 1'b0;
    unique case (opc)
      OPC_REGFORM: begin
        use_rd = 1'b1;
        case (fn)
          FN_ADD_T: kind = K_ADD_T;
          FN_ADD_W: kind = K_ADD_W;
          FN_SUB_T: kind = K_SUB_T;
          FN_SUB_W: kind = K_SUB_W;
          FN_AND:   kind = K_AND;
          FN_OR:    kind = K_OR;
          FN_XOR:   kind = K_XOR;
          FN_LESS:  kind = K_LESS;
          FN_SHL:   kind = K_SHL;
          FN_SHR: begin
            if (rs_field[4:1] == 4'b0000) begin
              if (rs_field[0] && ROT_EN) kind = K_ROR;
              else if (!rs_field[0])     kind = K_SHR;
            end
          end
          default: kind = K_NONE;
        endcase
      end
      OPC_ADDI_T: kind = K_ADDI_T;
      OPC_ADDI_W: kind = K_ADDI_W;
      OPC_UPPER:  kind = K_UPPER;
      default:    kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/trap_alu_adder.sv
module trap_alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw
);

  logic [DATA_W:0] a_ext, b_ext, wide;

  always_comb begin
    a_ext   = {a[DATA_W-1], a};
    b_ext   = {b[DATA_W-1], b};
    wide    = sub ? (a_ext - b_ext) : (a_ext + b_ext);
    sum     = wide[DATA_W-1:0];
    ovf_raw = wide[DATA_W] ^ wide[DATA_W-1];
  end

endmodule

// File: rtl/trap_alu_shift.sv
module trap_alu_shift
  import trap_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit ROT_EN = 1'b1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  input  shift_kind_e       how,
  output logic [DATA_W-1:0] out
);

  localparam logic [SH_W:0] FULL = DATA_W[SH_W:0];

  logic [DATA_W-1:0] left_v, right_v, rot_v;
  logic [SH_W:0]     back_amt;

  always_comb begin
    left_v   = val << amt;
    right_v  = val >> amt;
    back_amt = FULL - {1'b0, amt};
  end

  generate
    if (ROT_EN) begin : g_rot
      always_comb rot_v = right_v | (val << back_amt);
    end else begin : g_norot
      always_comb rot_v = right_v;
    end
  endgenerate

  always_comb begin
    unique case (how)
      SH_LEFT:  out = left_v;
      SH_RIGHT: out = right_v;
      default:  out = rot_v;
    endcase
  end

endmodule

// File: rtl/trap_alu.sv
module trap_alu
  import trap_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter bit ROT_EN = 1'b1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  output logic [DATA_W-1:0]  result,
  output logic [REG_W-1:0]   dst_idx,
  output logic               wr_en,
  output logic               dst_drop,
  output logic               ovf_trap
);

  alu_kind_e         kind;
  logic              use_rd;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] imm_sx, imm_hi, add_b, sum, sh_out;
  logic              is_sub, is_imm, traps, ovf_raw, active;
  shift_kind_e       sh_how;

  trap_alu_decode #(.ROT_EN(ROT_EN)) u_dec (
    .opc      (instr[31:26]),
    .rs_field (instr[25:21]),
    .fn       (instr[5:0]),
    .kind     (kind),
    .use_rd   (use_rd)
  );

  always_comb begin
    imm    = instr[IMM_W-1:0];
    imm_sx = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    imm_hi = {imm, {(DATA_W-IMM_W){1'b0}}};
    is_sub = (kind == K_SUB_T) || (kind == K_SUB_W);
    is_imm = (kind == K_ADDI_T) || (kind == K_ADDI_W);
    traps  = (kind == K_ADD_T) || (kind == K_SUB_T) || (kind == K_ADDI_T);
    add_b  = is_imm ? imm_sx : rt_val;
    sh_how = (kind == K_SHL) ? SH_LEFT : ((kind == K_ROR) ? SH_ROT : SH_RIGHT);
  end

  trap_alu_adder #(.DATA_W(DATA_W)) u_add (
    .a       (rs_val),
    .b       (add_b),
    .sub     (is_sub),
    .sum     (sum),
    .ovf_raw (ovf_raw)
  );

  trap_alu_shift #(.DATA_W(DATA_W), .ROT_EN(ROT_EN)) u_sh (
    .val (rt_val),
    .amt (instr[6 +: SH_W]),
    .how (sh_how),
    .out (sh_out)
  );

  always_comb begin
    unique case (kind)
      K_ADD_T, K_ADD_W, K_SUB_T, K_SUB_W,
      K_ADDI_T, K_ADDI_W:       result = sum;
      K_AND:                    result = rs_val & rt_val;
      K_OR:                     result = rs_val | rt_val;
      K_XOR:                    result = rs_val ^ rt_val;
      K_LESS:                   result = {{(DATA_W-1){1'b0}},
                                          ($signed(rs_val) < $signed(rt_val))};
      K_UPPER:                  result = imm_hi;
      K_SHL, K_SHR, K_ROR:      result = sh_out;
      default:                  result = '0;
    endcase
  end

  always_comb begin
    active   = (kind != K_NONE);
    dst_idx  = !active ? '0 : (use_rd ? instr[15:11] : instr[20:16]);
    ovf_trap = traps && ovf_raw;
    dst_drop = active && (dst_idx == '0);
    wr_en    = active && !ovf_trap && (dst_idx != '0);
  end

  // Checks on the combined outputs of decoder, adder and write gate
  always_comb begin
    if (ovf_trap) begin
      a_r2_trap_blocks_write: assert (!wr_en)
        else $error("trap with write enabled");
    end
    if (kind == K_ADD_W || kind == K_SUB_W || kind == K_ADDI_W || kind == K_LESS) begin
      a_r3_no_overflow: assert (!ovf_trap)
        else $error("non-trapping operation raised a trap");
    end
    if (kind == K_LESS) begin
      a_r5_less_is_bit: assert (result[DATA_W-1:1] == '0)
        else $error("set-less-than gave more than one bit");
    end
    if (kind == K_UPPER) begin
      a_r6_upper_low_zero: assert (result[DATA_W-IMM_W-1:0] == '0)
        else $error("upper immediate low half not zero");
    end
    if (instr == '0) begin
      a_r9_zero_word_idle: assert (!wr_en && !ovf_trap)
        else $error("all-zero word had an effect");
    end
    if (dst_idx == '0) begin
      a_r10_no_write_r0: assert (!wr_en)
        else $error("write enabled to register 0");
    end
    if (!active) begin
      a_r12_unknown_quiet: assert (!wr_en && !dst_drop && !ovf_trap && result == '0)
        else $error("unrecognised word produced output");
    end
  end

endmodule

// File: tb/trap_alu_test.sv
module trap_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dst_idx;
  logic        wr_en, dst_drop, ovf_trap;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  trap_alu uut (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(result), .dst_idx(dst_idx), .wr_en(wr_en),
    .dst_drop(dst_drop), .ovf_trap(ovf_trap)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        wr, drop, trap;
    string       req;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] rf(input logic [5:0] fn, input logic [4:0] rs_i,
                                     input logic [4:0] rt_i, input logic [4:0] rd_i,
                                     input logic [4:0] sh);
    return {6'b000000, rs_i, rt_i, rd_i, sh, fn};
  endfunction

  function automatic logic [31:0] imf(input logic [5:0] opc, input logic [4:0] rs_i,
                                      input logic [4:0] rt_i, input logic [15:0] im);
    return {opc, rs_i, rt_i, im};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input string req);
    exp_t e;
    longint s;
    logic [31:0] simm;
    logic valid = 1'b0;
    logic [4:0] sh = w[10:6];
    e.res = '0; e.dst = '0; e.trap = 1'b0; e.req = req;
    simm = {{16{w[15]}}, w[15:0]};
    if (w[31:26] == 6'd0) begin
      e.dst = w[15:11];
      valid = 1'b1;
      case (w[5:0])
        6'b100000: begin s = longint'($signed(a)) + longint'($signed(b));
                         e.res = s[31:0]; e.trap = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        6'b100001: e.res = a + b;
        6'b100010: begin s = longint'($signed(a)) - longint'($signed(b));
                         e.res = s[31:0]; e.trap = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        6'b100011: e.res = a - b;
        6'b100100: e.res = a & b;
        6'b100101: e.res = a | b;
        6'b100110: e.res = a ^ b;
        6'b101010: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'b000000: e.res = b << sh;
        6'b000010: begin
          if (w[25:21] == 5'b00000) e.res = b >> sh;
          else if (w[25:21] == 5'b00001) e.res = (b >> sh) | (b << (6'd32 - {1'b0, sh}));
          else valid = 1'b0;
        end
        default: valid = 1'b0;
      endcase
    end else if (w[31:26] == 6'b001000 || w[31:26] == 6'b001001) begin
      valid = 1'b1; e.dst = w[20:16];
      s = longint'($signed(a)) + longint'($signed(simm));
      e.res = s[31:0];
      e.trap = (w[31:26] == 6'b001000) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
    end else if (w[31:26] == 6'b001111) begin
      valid = 1'b1; e.dst = w[20:16];
      e.res = {w[15:0], 16'h0000};
    end
    if (!valid) begin e.res = '0; e.dst = '0; e.trap = 1'b0; end
    e.drop = valid && (e.dst == 5'd0);
    e.wr   = valid && !e.trap && (e.dst != 5'd0);
    return e;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input string req);
    @(posedge clk);
    #1;
    instr = w; rs_val = a; rt_val = b;
    sb.push_back(model(w, a, b, req));
  endtask

  // Monitor: results are combinational, due before the falling edge of the same cycle
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (result !== e.res || dst_idx !== e.dst || wr_en !== e.wr ||
          dst_drop !== e.drop || ovf_trap !== e.trap) begin
        n_fail++;
        $display("FAIL %s instr=%h: got res=%h dst=%0d wr=%b drop=%b trap=%b, expected res=%h dst=%0d wr=%b drop=%b trap=%b",
                 e.req, instr, result, dst_idx, wr_en, dst_drop, ovf_trap,
                 e.res, e.dst, e.wr, e.drop, e.trap);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: idle zero word
    drive(32'h0, 32'h1234_5678, 32'h9abc_def0, "R9");
    // R1 / R2: overflow boundaries
    drive(rf(6'b100000, 5'd1, 5'd2, 5'd3, 5'd0), 32'h7fff_ffff, 32'h1, "R1");
    drive(rf(6'b100010, 5'd1, 5'd2, 5'd3, 5'd0), 32'h8000_0000, 32'h1, "R1");
    drive(rf(6'b100000, 5'd1, 5'd2, 5'd3, 5'd0), 32'h8000_0000, 32'hffff_ffff, "R1");
    drive(rf(6'b100000, 5'd1, 5'd2, 5'd4, 5'd0), 32'd5, 32'd7, "R2");
    drive(rf(6'b100010, 5'd1, 5'd2, 5'd4, 5'd0), 32'd5, 32'd7, "R2");
    // R3: wrapping forms
    drive(rf(6'b100001, 5'd1, 5'd2, 5'd5, 5'd0), 32'h7fff_ffff, 32'h1, "R3");
    drive(rf(6'b100011, 5'd1, 5'd2, 5'd5, 5'd0), 32'h8000_0000, 32'h1, "R3");
    drive(imf(6'b001001, 5'd1, 5'd6, 16'h0001), 32'h7fff_ffff, 32'h0, "R3");
    // R4: add-immediate sign extension and trap
    drive(imf(6'b001000, 5'd1, 5'd6, 16'hffff), 32'h0, 32'h0, "R4");
    drive(imf(6'b001000, 5'd1, 5'd6, 16'h0001), 32'h7fff_ffff, 32'h0, "R4");
    drive(imf(6'b001000, 5'd1, 5'd6, 16'h8000), 32'h8000_0000, 32'h0, "R4");
    // R5: signed compare
    drive(rf(6'b101010, 5'd1, 5'd2, 5'd7, 5'd0), 32'hffff_ffff, 32'd1, "R5");
    drive(rf(6'b101010, 5'd1, 5'd2, 5'd7, 5'd0), 32'd1, 32'hffff_ffff, "R5");
    drive(rf(6'b101010, 5'd1, 5'd2, 5'd7, 5'd0), 32'd9, 32'd9, "R5");
    // R6: upper immediate
    drive(imf(6'b001111, 5'd0, 5'd8, 16'habcd), 32'hffff_ffff, 32'h0, "R6");
    // R7: logical shifts
    drive(rf(6'b000000, 5'd0, 5'd2, 5'd9, 5'd31), 32'hffff_ffff, 32'h8000_0003, "R7");
    drive(rf(6'b000010, 5'd0, 5'd2, 5'd9, 5'd31), 32'h0, 32'h8000_0003, "R7");
    drive(rf(6'b000010, 5'd0, 5'd2, 5'd9, 5'd0), 32'h0, 32'hdead_beef, "R7");
    // R8: rotate right
    drive(rf(6'b000010, 5'd1, 5'd2, 5'd9, 5'd4), 32'h0, 32'h1234_5678, "R8");
    drive(rf(6'b000010, 5'd1, 5'd2, 5'd9, 5'd0), 32'h0, 32'hdead_beef, "R8");
    drive(rf(6'b000010, 5'd1, 5'd2, 5'd9, 5'd31), 32'h0, 32'h8000_0001, "R8");
    // R10: destination register 0
    drive(rf(6'b100101, 5'd1, 5'd2, 5'd0, 5'd0), 32'h1, 32'h2, "R10");
    drive(imf(6'b001001, 5'd1, 5'd0, 16'h0010), 32'h1, 32'h0, "R10");
    drive(rf(6'b100000, 5'd1, 5'd2, 5'd0, 5'd0), 32'h7fff_ffff, 32'h1, "R10");
    // R11: bitwise
    drive(rf(6'b100100, 5'd1, 5'd2, 5'd10, 5'd0), 32'hf0f0_ff00, 32'h0ff0_f0f0, "R11");
    drive(rf(6'b100101, 5'd1, 5'd2, 5'd10, 5'd0), 32'hf0f0_ff00, 32'h0ff0_f0f0, "R11");
    drive(rf(6'b100110, 5'd1, 5'd2, 5'd10, 5'd0), 32'hf0f0_ff00, 32'h0ff0_f0f0, "R11");
    // R12: unrecognised words
    drive(imf(6'b000100, 5'd1, 5'd2, 16'h0004), 32'h1, 32'h1, "R12");
    drive(rf(6'b000010, 5'd4, 5'd2, 5'd9, 5'd3), 32'h0, 32'hffff_ffff, "R12");
    drive(rf(6'b111111, 5'd1, 5'd2, 5'd9, 5'd0), 32'h5, 32'h6, "R12");
    // Random mix over all operations
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b, w;
      int pick;
      a = $urandom; b = $urandom;
      if (i % 4 == 0) a = {a[31], {31{~a[31]}}};
      pick = $urandom_range(0, 13);
      case (pick)
        0:  w = rf(6'b100000, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        1:  w = rf(6'b100001, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        2:  w = rf(6'b100010, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        3:  w = rf(6'b100011, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        4:  w = imf(6'b001000, 5'($urandom), 5'($urandom), 16'($urandom));
        5:  w = imf(6'b001001, 5'($urandom), 5'($urandom), 16'($urandom));
        6:  w = rf(6'b100100, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        7:  w = rf(6'b100101, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        8:  w = rf(6'b100110, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        9:  w = rf(6'b101010, 5'($urandom), 5'($urandom), 5'($urandom), 5'd0);
        10: w = imf(6'b001111, 5'($urandom), 5'($urandom), 16'($urandom));
        11: w = rf(6'b000000, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        12: w = rf(6'b000010, 5'd0, 5'($urandom), 5'($urandom), 5'($urandom));
        default: w = rf(6'b000010, 5'd1, 5'($urandom), 5'($urandom), 5'($urandom));
      endcase
      drive(w, a, b, "R1/R3 random (R4 R5 R6 R7 R8 R11)");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule